// File: doc/BRIEF.md
# USB Event Status Flag Collector

This block gathers bus events reported by a USB serial engine into sticky status bits and raises one USB interrupt request. Four kinds of event are tracked: suspend, resume, bus reset, and a host access to any of the endpoint FIFOs. Each event has its own flag, so service code can find out which event happened and which endpoint the host touched.

Software sees two registers. The control/status register holds the suspend, resume and bus-reset flags. The access register holds one flag per endpoint. A flag stays set until software writes a 0 to that bit. The interrupt output is a single-cycle pulse. It feeds the USB request flag of the interrupt controller.

Top module: `usbev_collector`

## Requirements
- R1: While reset is asserted, and after its release, both registers read 0 and the interrupt pulse is low.
- R2: A cycle with `ev_suspend` high sets bit 0 of `ctl_rd_data`, starting in the next cycle.
- R3: A cycle with `ev_resume` high sets bit 3 of `ctl_rd_data`, starting in the next cycle.
- R4: A cycle with `ev_busreset` high sets bit 2 of `ctl_rd_data`, starting in the next cycle.
- R5: A cycle with bit k of `ev_fifo_access` high sets bit k of `acc_rd_data` in the next cycle, for k = 0..NUM_EP-1. The other access bits do not change.
- R6: A flag stays set when its register is not written, and when a 1 is written to that bit.
- R7: Writing 0 to a flag bit clears it in the next cycle. A write to one register leaves the other register unchanged.
- R8: If a set event and a clearing write land on the same bit in the same cycle, the bit ends up set.
- R9: Control bits 1 and 4..REG_W-1 always read 0, as do access bits NUM_EP..REG_W-1, even after writes of 1.
- R10: `usb_irq_pulse` is high in the cycle after any cycle in which at least one event input is high, even if the matching flag was already set. Otherwise it is low.
- R11: When several events occur in the same cycle, every one of them sets its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_suspend | input | 1 | Suspend seen on the bus |
| ev_resume | input | 1 | Resume seen on the bus |
| ev_busreset | input | 1 | Bus reset detected |
| ev_fifo_access | input | NUM_EP | Host access strobe, one per endpoint FIFO |
| ctl_wr_en | input | 1 | Write strobe for the control/status register |
| ctl_wr_data | input | REG_W | Write data; a 0 in a flag bit clears that flag |
| acc_wr_en | input | 1 | Write strobe for the access register |
| acc_wr_data | input | REG_W | Write data; a 0 in a flag bit clears that flag |
| ctl_rd_data | output | REG_W | Control/status register value |
| acc_rd_data | output | REG_W | Access register value |
| usb_irq_pulse | output | 1 | One-cycle USB interrupt request |

## Verification
The bench uses the default build: NUM_EP = 4 and REG_W = 8. With these values the access register has four live bits and four bits that must stay 0. The bench can therefore write 1 to every unused position in both registers and check that each one still reads 0. A set of four endpoints is also small enough for random cycles to often hit every endpoint, including the cases where a set and a clear fall on the same bit in the same cycle.

// File: rtl/usbev_pkg.sv
package usbev_pkg;
  // Bit positions inside the control/status register
  localparam int unsigned SUSP_POS = 0;
  localparam int unsigned BRST_POS = 2;
  localparam int unsigned RSM_POS  = 3;

  typedef struct packed {
    logic suspend;
    logic resume;
    logic busrst;
  } usbev_bus_t;

  function automatic logic is_ctl_flag(input int unsigned pos);
    return (pos == SUSP_POS) || (pos == BRST_POS) || (pos == RSM_POS);
  endfunction

  function automatic logic ctl_set_for(input int unsigned pos, input usbev_bus_t ev);
    logic s;
    s = 1'b0;
    if (pos == SUSP_POS) s = ev.suspend;
    if (pos == BRST_POS) s = ev.busrst;
    if (pos == RSM_POS)  s = ev.resume;
    return s;
  endfunction
endpackage

// File: rtl/usbev_rst_sync.sv
module usbev_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/usbev_flag_bit.sv
module usbev_flag_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  output logic q_o
);
  logic q;
  logic en;
  logic d;

  // a hardware set outranks a software clear
  always_comb begin
    en = set_i | (wr_en_i & ~wr_bit_i);
    d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= d;
  end

  assign q_o = q;
endmodule

// File: rtl/usbev_ctl_reg.sv
module usbev_ctl_reg
  import usbev_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  usbev_bus_t       ev_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_o
);
  logic [REG_W-1:0] unused_wr;

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (is_ctl_flag(i)) begin : g_flag
      logic set_w;
      assign set_w = ctl_set_for(i, ev_i);
      usbev_flag_bit u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_w),
        .wr_en_i  (wr_en_i),
        .wr_bit_i (wr_data_i[i]),
        .q_o      (rd_o[i])
      );
      assign unused_wr[i] = 1'b0;
    end else begin : g_zero
      assign rd_o[i]      = 1'b0;
      assign unused_wr[i] = wr_data_i[i];
    end
  end
endmodule

// File: rtl/usbev_acc_reg.sv
module usbev_acc_reg #(
  parameter int unsigned NUM_EP = 4,
  parameter int unsigned REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] access_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_o
);
  logic [REG_W-1:0] unused_wr;

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (i < NUM_EP) begin : g_flag
      usbev_flag_bit u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (access_i[i]),
        .wr_en_i  (wr_en_i),
        .wr_bit_i (wr_data_i[i]),
        .q_o      (rd_o[i])
      );
      assign unused_wr[i] = 1'b0;
    end else begin : g_zero
      assign rd_o[i]      = 1'b0;
      assign unused_wr[i] = wr_data_i[i];
    end
  end
endmodule

// File: rtl/usbev_irq_gen.sv
module usbev_irq_gen
  import usbev_pkg::*;
#(
  parameter int unsigned NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  usbev_bus_t        ev_i,
  input  logic [NUM_EP-1:0] access_i,
  output logic              irq_o
);
  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = ev_i.suspend | ev_i.resume | ev_i.busrst | (|access_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/usbev_collector.sv
module usbev_collector
  import usbev_pkg::*;
#(
  parameter int unsigned NUM_EP = 4,
  parameter int unsigned REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_suspend,
  input  logic              ev_resume,
  input  logic              ev_busreset,
  input  logic [NUM_EP-1:0] ev_fifo_access,
  input  logic              ctl_wr_en,
  input  logic [REG_W-1:0]  ctl_wr_data,
  input  logic              acc_wr_en,
  input  logic [REG_W-1:0]  acc_wr_data,
  output logic [REG_W-1:0]  ctl_rd_data,
  output logic [REG_W-1:0]  acc_rd_data,
  output logic              usb_irq_pulse
);
  logic       rst_n_sync;
  usbev_bus_t bus_ev;

  always_comb begin
    bus_ev.suspend = ev_suspend;
    bus_ev.resume  = ev_resume;
    bus_ev.busrst  = ev_busreset;
  end

  usbev_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  usbev_ctl_reg #(.REG_W(REG_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .ev_i      (bus_ev),
    .wr_en_i   (ctl_wr_en),
    .wr_data_i (ctl_wr_data),
    .rd_o      (ctl_rd_data)
  );

  usbev_acc_reg #(.NUM_EP(NUM_EP), .REG_W(REG_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .access_i  (ev_fifo_access),
    .wr_en_i   (acc_wr_en),
    .wr_data_i (acc_wr_data),
    .rd_o      (acc_rd_data)
  );

  usbev_irq_gen #(.NUM_EP(NUM_EP)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .ev_i     (bus_ev),
    .access_i (ev_fifo_access),
    .irq_o    (usb_irq_pulse)
  );
endmodule

// File: rtl/usbev_collector_chk.sv
module usbev_collector_chk #(
  parameter int unsigned NUM_EP = 4,
  parameter int unsigned REG_W  = 8
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              ev_suspend,
  input logic              ev_resume,
  input logic              ev_busreset,
  input logic [NUM_EP-1:0] ev_fifo_access,
  input logic              ctl_wr_en,
  input logic [REG_W-1:0]  ctl_wr_data,
  input logic              acc_wr_en,
  input logic [REG_W-1:0]  ctl_rd_data,
  input logic [REG_W-1:0]  acc_rd_data,
  input logic              usb_irq_pulse
);
  localparam logic [REG_W-1:0] CTL_LIVE = REG_W'(8'h0D);
  localparam logic [REG_W-1:0] ACC_LIVE = REG_W'((1 << NUM_EP) - 1);

  assert_suspend_set_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    ev_suspend |=> ctl_rd_data[0]);

  assert_resume_set_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    ev_resume |=> ctl_rd_data[3]);

  assert_busrst_set_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    ev_busreset |=> ctl_rd_data[2]);

  assert_fifo_set_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (|ev_fifo_access) |=>
      ((acc_rd_data[NUM_EP-1:0] & $past(ev_fifo_access)) == $past(ev_fifo_access)));

  assert_ctl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ctl_wr_en |=> ((ctl_rd_data & $past(ctl_rd_data)) == $past(ctl_rd_data)));

  assert_acc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !acc_wr_en |=> ((acc_rd_data & $past(acc_rd_data)) == $past(acc_rd_data)));

  assert_susp_clear_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctl_wr_en && !ctl_wr_data[0] && !ev_suspend) |=> !ctl_rd_data[0]);

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((ctl_rd_data & ~CTL_LIVE) == '0) && ((acc_rd_data & ~ACC_LIVE) == '0));

  assert_irq_on_event_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ev_suspend || ev_resume || ev_busreset || (|ev_fifo_access)) |=> usb_irq_pulse);

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(ev_suspend || ev_resume || ev_busreset || (|ev_fifo_access)) |=> !usb_irq_pulse);
endmodule

bind usbev_collector usbev_collector_chk #(.NUM_EP(NUM_EP), .REG_W(REG_W)) chk_i (
  .clk            (clk),
  .rst_n_s        (rst_n_sync),
  .ev_suspend     (ev_suspend),
  .ev_resume      (ev_resume),
  .ev_busreset    (ev_busreset),
  .ev_fifo_access (ev_fifo_access),
  .ctl_wr_en      (ctl_wr_en),
  .ctl_wr_data    (ctl_wr_data),
  .acc_wr_en      (acc_wr_en),
  .ctl_rd_data    (ctl_rd_data),
  .acc_rd_data    (acc_rd_data),
  .usb_irq_pulse  (usb_irq_pulse)
);

// File: tb/usbev_collector_tb_top.sv
module usbev_collector_tb_top;
  localparam int unsigned NUM_EP = 4;
  localparam int unsigned REG_W  = 8;

  logic              clk;
  logic              rst_n;
  logic              ev_suspend, ev_resume, ev_busreset;
  logic [NUM_EP-1:0] ev_fifo_access;
  logic              ctl_wr_en, acc_wr_en;
  logic [REG_W-1:0]  ctl_wr_data, acc_wr_data;
  logic [REG_W-1:0]  ctl_rd_data, acc_rd_data;
  logic              usb_irq_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] ctl_m, acc_m;
  logic       irq_m;
  bit         done = 0;

  usbev_collector #(.NUM_EP(NUM_EP), .REG_W(REG_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_suspend(ev_suspend), .ev_resume(ev_resume), .ev_busreset(ev_busreset),
    .ev_fifo_access(ev_fifo_access),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .acc_wr_en(acc_wr_en), .acc_wr_data(acc_wr_data),
    .ctl_rd_data(ctl_rd_data), .acc_rd_data(acc_rd_data),
    .usb_irq_pulse(usb_irq_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // model of the next register value: write 0 clears, set wins, dead bits 0
  function automatic logic [7:0] ctl_next(input logic [7:0] cur, input logic we,
      input logic [7:0] wd, input logic s, input logic r, input logic b);
    logic [7:0] n;
    n = we ? (cur & wd) : cur;
    n = n | {4'b0, r, b, 1'b0, s};
    return n & 8'h0D;
  endfunction

  function automatic logic [7:0] acc_next(input logic [7:0] cur, input logic we,
      input logic [7:0] wd, input logic [3:0] fa);
    logic [7:0] n;
    n = we ? (cur & wd) : cur;
    n = n | {4'b0, fa};
    return n & 8'h0F;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " ctl"}, ctl_rd_data, ctl_m);
    chk({tag, " acc"}, acc_rd_data, acc_m);
    chk({tag, " irq R10"}, {7'b0, usb_irq_pulse}, {7'b0, irq_m});
  endtask

  // drive at negedge, predict, compare at the following negedge
  task automatic step(input string tag, input logic s, input logic r, input logic b,
      input logic [3:0] fa, input logic cwe, input logic [7:0] cwd,
      input logic awe, input logic [7:0] awd);
    ev_suspend = s; ev_resume = r; ev_busreset = b; ev_fifo_access = fa;
    ctl_wr_en = cwe; ctl_wr_data = cwd; acc_wr_en = awe; acc_wr_data = awd;
    ctl_m = ctl_next(ctl_m, cwe, cwd, s, r, b);
    acc_m = acc_next(acc_m, awe, awd, fa);
    irq_m = s | r | b | (|fa);
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    ev_suspend = 0; ev_resume = 0; ev_busreset = 0; ev_fifo_access = '0;
    ctl_wr_en = 0; ctl_wr_data = '0; acc_wr_en = 0; acc_wr_data = '0;
    ctl_m = '0; acc_m = '0; irq_m = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 after release");

    step("R2 suspend",  1,0,0,4'h0, 0,8'h00, 0,8'h00);
    step("R3 resume",   0,1,0,4'h0, 0,8'h00, 0,8'h00);
    step("R4 busreset", 0,0,1,4'h0, 0,8'h00, 0,8'h00);
    step("R6 hold",     0,0,0,4'h0, 0,8'h00, 0,8'h00);
    step("R6 write ones", 0,0,0,4'h0, 1,8'hFF, 1,8'hFF);
    step("R9 ones unused", 0,0,0,4'h0, 1,8'hF2, 1,8'hF0);
    for (int k = 0; k < 4; k++) step("R5 fifo", 0,0,0,4'(1 << k), 0,8'h00, 0,8'h00);
    step("R7 clear ctl only", 0,0,0,4'h0, 1,8'h00, 0,8'h00);
    step("R7 clear acc bit1", 0,0,0,4'h0, 0,8'h00, 1,8'hFD);
    step("R8 set beats clear", 1,0,0,4'h4, 1,8'h00, 1,8'h00);
    step("R10 already set", 1,0,0,4'h0, 0,8'h00, 0,8'h00);
    step("R10 quiet", 0,0,0,4'h0, 0,8'h00, 0,8'h00);
    step("R7 clear all", 0,0,0,4'h0, 1,8'h00, 1,8'h00);
    step("R11 all events", 1,1,1,4'hF, 0,8'h00, 0,8'h00);
    step("R7 clear all again", 0,0,0,4'h0, 1,8'h00, 1,8'h00);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom();
      step("R11 random",
           r[0] & r[1], r[2] & r[3], r[4] & r[5], r[9:6] & r[13:10],
           r[14], r[22:15], r[23], r[31:24]);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule